// File: doc/BRIEF.md
# Instruction Tightly-Coupled Memory Region Control

This block holds the 32-bit control word that places a tightly-coupled instruction memory in the physical address space. Software reads and writes it through a register access port. Each access carries a privilege flag and a security-world flag. The block checks every access against a write-lock input and a permission input for the non-secure world. When an access is refused, it raises an undefined-instruction exception and leaves the stored state unchanged.

The memory size is fixed at build time by the parameter `TCM_KB`. The block reports that size in a read-only field. Base bits that fall inside the memory's own span are dropped.

For every instruction fetch address the block decodes whether the fetch lands in the enabled memory window. A static strap selects whether the window is enabled at address zero straight out of reset. When it is, the first fetches after reset can be served from the local memory.

Top module: `tcm_region_reg`

## Requirements
- R1: While reset is asserted and after it is released, the stored base is 0 and the enable bit (bit 0) equals `init_en_strap`. A legal read straight after reset returns the size code in bits [6:2], the strap in bit 0, and zeros elsewhere.
- R2: A legal write loads the base from `acc_wdata[31:12]` and the enable from `acc_wdata[0]`. Both are visible from the cycle after the write, in read data and in `fetch_hit`. A legal read returns `{base, 5'b0, size_code, 1'b0, en}` on `acc_rdata` in the cycle of the read.
- R3: Bits [6:2] always read the size code: 00000 for 0 KB, 00011 for 4 KB, 00100 for 8 KB, 00101 for 16 KB, 00110 for 32 KB. Write data in those bits has no effect.
- R4: Bits [11:7] and bit 1 read as zero, and values written there are dropped.
- R5: Base bits [log2(size)-1:12] are ignored. A write stores them as zero, they read back as zero, and they play no part in the hit decode. The default is 16 KB, which covers bits [13:12].
- R6: Any access (`acc_valid` high) with `acc_priv` low raises `undef_exc`. It changes nothing, and `acc_rdata` stays zero.
- R7: A secure (`acc_nonsecure` low) privileged write while `wr_lock` is high raises `undef_exc` and leaves the register unchanged. Secure privileged reads still succeed while the lock is high.
- R8: A non-secure access, read or write, while `ns_access_ok` is low raises `undef_exc` and has no effect. With `ns_access_ok` high, non-secure privileged reads and writes succeed whatever the state of `wr_lock`.
- R9: `fetch_hit` is high exactly when the enable is 1, the size is nonzero, and `fetch_addr[31:log2(size)]` equals the same bits of the stored base.
- R10: `undef_exc` is high only in a cycle with `acc_valid` high and a refused access, in that same cycle. `acc_rdata` is zero in every cycle without a legal read.
- R11: With the strap high, a fetch to address 0 hits in the first cycle after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| init_en_strap | input | 1 | Static strap giving the enable bit's reset value |
| wr_lock | input | 1 | Blocks secure privileged writes when high |
| ns_access_ok | input | 1 | Permits non-secure accesses when high |
| acc_valid | input | 1 | Register access strobe |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_priv | input | 1 | Access is privileged |
| acc_nonsecure | input | 1 | Access comes from the non-secure world |
| acc_wdata | input | 32 | Write data |
| acc_rdata | output | 32 | Read data, zero unless a legal read |
| fetch_addr | input | 32 | Instruction fetch address |
| fetch_hit | output | 1 | Fetch falls in the enabled memory window |
| undef_exc | output | 1 | Undefined-instruction exception pulse |

## Verification
`undef_exc`, `acc_rdata` and `fetch_hit` are combinational from the current inputs and the stored state, so they are due in the same cycle as the stimulus. A legal write only shows up one clock edge later. The bench drives every input on the falling edge and compares all three outputs 1 ns later against a bench model. It updates that model only after the comparison, so a write is first expected in the following cycle. After each reset release the checks are made in the first cycle, before any rising edge.

// File: rtl/tcm_region_pkg.sv
package tcm_region_pkg;

    typedef struct packed {
        logic [19:0] base;   // address bits [31:12]
        logic        en;
    } region_t;

    // lowest address bit that takes part in the window compare
    function automatic int unsigned lsb_of(int unsigned kb);
        int unsigned l;
        if (kb == 0) return 12;
        l = $clog2(kb) + 10;
        return (l < 12) ? 12 : l;
    endfunction

    // read-only size field value
    function automatic logic [4:0] code_of(int unsigned kb);
        if (kb == 0) return 5'd0;
        return 5'($clog2(kb) + 1);
    endfunction

    // keeps base bits at or above the window size
    function automatic logic [19:0] mask_of(int unsigned kb);
        int unsigned sh;
        sh = lsb_of(kb) - 12;
        return ~((20'd1 << sh) - 20'd1);
    endfunction

endpackage

// File: rtl/tcm_access_check.sv
module tcm_access_check (
    input  logic acc_valid,
    input  logic acc_write,
    input  logic acc_priv,
    input  logic acc_nonsecure,
    input  logic wr_lock,
    input  logic ns_access_ok,
    output logic rd_ok,
    output logic wr_ok,
    output logic refused
);
    logic user_bad;
    logic world_bad;
    logic lock_bad;

    always_comb begin
        user_bad  = !acc_priv;
        world_bad = acc_nonsecure && !ns_access_ok;
        lock_bad  = acc_write && !acc_nonsecure && acc_priv && wr_lock;
        refused   = acc_valid && (user_bad || world_bad || lock_bad);
        rd_ok     = acc_valid && !acc_write && !refused;
        wr_ok     = acc_valid &&  acc_write && !refused;
    end
endmodule

// File: rtl/tcm_hit_decode.sv
module tcm_hit_decode #(
    parameter int unsigned TCM_KB = 16,
    parameter int unsigned LSB    = 14
) (
    input  tcm_region_pkg::region_t region,
    input  logic [31:0]             fetch_addr,
    output logic                    hit
);
    logic unused_low;
    assign unused_low = ^fetch_addr[LSB-1:0];

    generate
        if (TCM_KB == 0) begin : g_none
            logic unused_reg;
            assign unused_reg = ^region;
            assign hit = 1'b0;
        end else begin : g_cmp
            logic unused_base;
            if (LSB > 12) begin : g_drop
                assign unused_base = ^region.base[LSB-13:0];
            end else begin : g_keep
                assign unused_base = 1'b0;
            end
            assign hit = region.en &&
                         (fetch_addr[31:LSB] == region.base[19:LSB-12]);
        end
    endgenerate
endmodule

// File: rtl/tcm_readback.sv
module tcm_readback #(
    parameter logic [4:0] SIZE_CODE = 5'd5
) (
    input  logic                    rd_ok,
    input  tcm_region_pkg::region_t region,
    output logic [31:0]             rdata
);
    always_comb begin
        rdata = '0;
        if (rd_ok) begin
            rdata[31:12] = region.base;
            rdata[6:2]   = SIZE_CODE;
            rdata[0]     = region.en;
        end
    end
endmodule

// File: rtl/tcm_region_reg.sv
module tcm_region_reg #(
    parameter int unsigned TCM_KB = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        init_en_strap,
    input  logic        wr_lock,
    input  logic        ns_access_ok,
    input  logic        acc_valid,
    input  logic        acc_write,
    input  logic        acc_priv,
    input  logic        acc_nonsecure,
    input  logic [31:0] acc_wdata,
    output logic [31:0] acc_rdata,
    input  logic [31:0] fetch_addr,
    output logic        fetch_hit,
    output logic        undef_exc
);
    import tcm_region_pkg::*;

    localparam int unsigned LSB       = lsb_of(TCM_KB);
    localparam logic [4:0]  SIZE_CODE = code_of(TCM_KB);
    localparam logic [19:0] BASE_MASK = mask_of(TCM_KB);

    region_t state_d, state_q;
    logic    rd_ok, wr_ok, refused;

    // observation points for the bound checker
    logic [19:0] cur_base;
    logic        cur_en;
    assign cur_base = state_q.base;
    assign cur_en   = state_q.en;

    logic unused_wbits;
    assign unused_wbits = ^acc_wdata[11:1];

    tcm_access_check u_check (
        .acc_valid     (acc_valid),
        .acc_write     (acc_write),
        .acc_priv      (acc_priv),
        .acc_nonsecure (acc_nonsecure),
        .wr_lock       (wr_lock),
        .ns_access_ok  (ns_access_ok),
        .rd_ok         (rd_ok),
        .wr_ok         (wr_ok),
        .refused       (refused)
    );

    always_comb begin
        state_d = state_q;
        if (wr_ok) begin
            state_d.base = acc_wdata[31:12] & BASE_MASK;
            state_d.en   = acc_wdata[0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q.base <= '0;
            state_q.en   <= init_en_strap;
        end else begin
            state_q <= state_d;
        end
    end

    tcm_readback #(.SIZE_CODE(SIZE_CODE)) u_rb (
        .rd_ok  (rd_ok),
        .region (state_q),
        .rdata  (acc_rdata)
    );

    tcm_hit_decode #(.TCM_KB(TCM_KB), .LSB(LSB)) u_hit (
        .region     (state_q),
        .fetch_addr (fetch_addr),
        .hit        (fetch_hit)
    );

    assign undef_exc = refused;

endmodule

// File: rtl/tcm_region_reg_chk.sv
module tcm_region_reg_chk #(
    parameter int unsigned TCM_KB = 16
) (
    input logic        clk,
    input logic        rst_n,
    input logic        acc_valid,
    input logic        acc_write,
    input logic        acc_priv,
    input logic [31:0] acc_wdata,
    input logic [31:0] acc_rdata,
    input logic        fetch_hit,
    input logic        undef_exc,
    input logic [19:0] cur_base,
    input logic        cur_en
);
    localparam logic [4:0] CODE = (TCM_KB == 0) ? 5'd0 : 5'($clog2(TCM_KB) + 1);

    logic unused_base;
    assign unused_base = ^cur_base;

    // R6: user-mode access always refused
    a_r6_user_undef: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !acc_priv) |-> undef_exc);

    // R7 / R8: refused access leaves state untouched
    a_r7_refused_no_update: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && undef_exc) |=> ($stable(cur_base) && $stable(cur_en)));

    // R10: exception only during an access
    a_r10_undef_needs_access: assert property (@(posedge clk) disable iff (!rst_n)
        undef_exc |-> acc_valid);

    // R10: no read data outside a legal read
    a_r10_rdata_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !(acc_valid && !acc_write && !undef_exc) |-> (acc_rdata == 32'd0));

    // R3: size field on legal reads
    a_r3_size_code: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !acc_write && !undef_exc) |-> (acc_rdata[6:2] == CODE));

    // R4: reserved bits read zero
    a_r4_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_rdata[11:7] == 5'd0) && (acc_rdata[1] == 1'b0));

    // R2: accepted write lands on the next edge
    a_r2_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_write && !undef_exc) |=> (cur_en == $past(acc_wdata[0])));

    // R9: no hit while disabled
    a_r9_hit_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_hit |-> cur_en);

endmodule

bind tcm_region_reg tcm_region_reg_chk #(.TCM_KB(TCM_KB)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .acc_valid (acc_valid),
    .acc_write (acc_write),
    .acc_priv  (acc_priv),
    .acc_wdata (acc_wdata),
    .acc_rdata (acc_rdata),
    .fetch_hit (fetch_hit),
    .undef_exc (undef_exc),
    .cur_base  (cur_base),
    .cur_en    (cur_en)
);

// File: tb/tcm_region_reg_bench.sv
`timescale 1ns/1ps
module tcm_region_reg_bench;
    localparam int unsigned TCM_KB = 16;
    localparam int unsigned LSB    = 14;
    localparam logic [4:0]  CODE   = 5'b00101;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        init_en_strap = 1'b0;
    logic        wr_lock = 1'b0;
    logic        ns_access_ok = 1'b0;
    logic        acc_valid = 1'b0;
    logic        acc_write = 1'b0;
    logic        acc_priv = 1'b0;
    logic        acc_nonsecure = 1'b0;
    logic [31:0] acc_wdata = '0;
    logic [31:0] acc_rdata;
    logic [31:0] fetch_addr = '0;
    logic        fetch_hit;
    logic        undef_exc;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    logic [19:0] m_base;
    logic        m_en;

    always #2.5 clk = ~clk;

    tcm_region_reg #(.TCM_KB(TCM_KB)) u_tcm_region_reg (
        .clk, .rst_n, .init_en_strap, .wr_lock, .ns_access_ok,
        .acc_valid, .acc_write, .acc_priv, .acc_nonsecure,
        .acc_wdata, .acc_rdata, .fetch_addr, .fetch_hit, .undef_exc
    );

    function automatic logic f_undef(logic v, logic w, logic p, logic ns,
                                     logic lk, logic ok);
        return v && (!p || (ns && !ok) || (w && !ns && lk));
    endfunction

    function automatic logic [31:0] f_rdata(logic v, logic w, logic u,
                                            logic [19:0] b, logic e);
        if (v && !w && !u) return {b, 5'b0, CODE, 1'b0, e};
        return 32'd0;
    endfunction

    function automatic logic f_hit(logic e, logic [19:0] b, logic [31:0] a);
        return e && (a[31:LSB] == b[19:LSB-12]);
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // drive on falling edge, compare 1 ns later, then advance model
    task automatic step(string req, logic v, logic w, logic p, logic ns,
                        logic lk, logic ok, logic [31:0] wd, logic [31:0] fa);
        logic u;
        @(negedge clk);
        acc_valid = v; acc_write = w; acc_priv = p; acc_nonsecure = ns;
        wr_lock = lk; ns_access_ok = ok; acc_wdata = wd; fetch_addr = fa;
        #1;
        u = f_undef(v, w, p, ns, lk, ok);
        chk({req, " undef"}, {31'd0, undef_exc}, {31'd0, u});
        chk({req, " rdata"}, acc_rdata, f_rdata(v, w, u, m_base, m_en));
        chk({req, " hit"}, {31'd0, fetch_hit}, {31'd0, f_hit(m_en, m_base, fa)});
        if (v && w && !u) begin
            m_base = wd[31:12] & 20'hFFFFC;
            m_en   = wd[0];
        end
    endtask

    task automatic do_reset(logic strap);
        @(negedge clk);
        rst_n = 1'b0; init_en_strap = strap; acc_valid = 1'b0;
        repeat (3) @(negedge clk);
        m_base = '0; m_en = strap;
        rst_n = 1'b1;
        acc_valid = 1'b1; acc_write = 1'b0; acc_priv = 1'b1;
        acc_nonsecure = 1'b0; wr_lock = 1'b0; ns_access_ok = 1'b0;
        fetch_addr = 32'h0000_0100;
        #1;
        chk("R1 reset read", acc_rdata, {20'd0, 5'b0, CODE, 1'b0, strap});
        chk("R11 first-cycle hit", {31'd0, fetch_hit}, {31'd0, strap});
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_bad++; n_chk++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] seed;
        seed = 32'd1234;
        void'($urandom(seed));

        do_reset(1'b0);
        // R2 R3 R4 R5: bits 13:12, size, reserved all set in write data
        step("R2 write", 1, 1, 1, 0, 0, 0, 32'h0001_3FFF, 32'h0);
        step("R5 readback", 1, 0, 1, 0, 0, 0, 32'h0, 32'h0001_3FFC);
        chk("R3 R4 R5 word", acc_rdata, 32'h0001_0015);
        step("R9 edge miss", 0, 0, 1, 0, 0, 0, 32'h0, 32'h0001_4000);
        step("R9 low miss", 0, 0, 1, 0, 0, 0, 32'h0, 32'h0000_FFFC);
        // R7 lock
        step("R7 locked write", 1, 1, 1, 0, 1, 0, 32'h0008_0001, 32'h0);
        step("R7 locked read", 1, 0, 1, 0, 1, 0, 32'h0, 32'h0008_0000);
        chk("R7 unchanged", acc_rdata, 32'h0001_0015);
        // R8 world permission
        step("R8 ns write denied", 1, 1, 1, 1, 0, 0, 32'h0008_0001, 32'h0);
        step("R8 ns read denied", 1, 0, 1, 1, 0, 0, 32'h0, 32'h0001_0000);
        step("R8 ns write ok", 1, 1, 1, 1, 1, 1, 32'h0008_0001, 32'h0);
        step("R8 ns read ok", 1, 0, 1, 1, 1, 1, 32'h0, 32'h0008_1234);
        chk("R8 ns write landed", acc_rdata, 32'h0008_0015);
        // R6 user mode
        step("R6 user read", 1, 0, 0, 0, 0, 1, 32'h0, 32'h0);
        step("R6 user write", 1, 1, 0, 0, 0, 1, 32'h0000_0000, 32'h0008_0000);
        step("R9 disable", 1, 1, 1, 0, 0, 0, 32'h0008_0000, 32'h0008_0000);
        step("R9 disabled miss", 0, 0, 1, 0, 0, 0, 32'h0, 32'h0008_0000);
        step("R10 idle", 0, 1, 0, 1, 1, 0, 32'hFFFF_FFFF, 32'h0);

        for (int i = 0; i < 3000; i++) begin
            logic [31:0] fa;
            if ($urandom_range(1, 0) == 1)
                fa = {m_base, 12'd0} ^ ($urandom() & 32'h0000_7FFF);
            else
                fa = $urandom();
            step("R10 random", $urandom_range(9, 0) < 7, $urandom_range(1, 0) == 1,
                 $urandom_range(9, 0) < 8, $urandom_range(1, 0) == 1,
                 $urandom_range(9, 0) < 3, $urandom_range(9, 0) < 6,
                 $urandom(), fa);
        end

        do_reset(1'b1);
        step("R11 base0 hit", 0, 0, 1, 0, 0, 0, 32'h0, 32'h0000_3FFC);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule